// File: doc/BRIEF.md
# Paged Program Counter with Return Stack

This block holds the fetch address of a small controller core with a 1K-word program space, and a two-level stack of return addresses. On every clock it applies one operation chosen by a 3-bit operation code. It can advance by one word, advance by two words to skip an instruction, or take a new low byte from the ALU. It can also take a short jump or call that is paged by a status bit, take a long jump or call with a full 10-bit target, or return from a subroutine.

The 10-bit address is treated as three fields: a low byte, a middle bit and a top page bit. Short branches and ALU writes assemble the address field by field. The low byte comes from the operand or the ALU, the middle bit comes from the operand or is forced to zero, and the page bit comes from the status register. Long branches and returns replace the whole address. Calls push the address of the following word. The stack never reports an error: an extra push drops the oldest entry, and a pop of an empty stack repeats the last address it delivered. Instruction decoding and fetching belong to the surrounding core.

Top module: `pcu_top`

## Requirements
- R1: While `rst` is high at a clock edge, `fetch_addr` and every stack word become zero, whatever the operation inputs are.
- R2: Operation code 0 (step) loads `fetch_addr + 1` modulo 1024, so 3FF goes to 000.
- R3: Operation code 1 (skip) loads `fetch_addr + 2` modulo 1024, so 3FE goes to 000 and 3FF goes to 001.
- R4: Operation code 2 (ALU write) loads bit 9 from `page_sel`, bit 8 as 0, and bits 7..0 from `alu_res`.
- R5: Operation code 3 (short jump) loads bit 9 from `page_sel` and bits 8..0 from `imm_addr[8:0]`. `imm_addr[9]` has no effect.
- R6: Operation code 4 (short call) loads bit 9 from `page_sel`, bit 8 as 0, and bits 7..0 from `imm_addr[7:0]`. It pushes the old `fetch_addr + 1` (modulo 1024).
- R7: Operation code 5 (long jump) loads all 10 bits from `imm_addr`. `page_sel` has no effect.
- R8: Operation code 6 (long call) loads all 10 bits from `imm_addr` and pushes the old `fetch_addr + 1` (modulo 1024), so a call from 3FF pushes 000.
- R9: Operation code 7 (return) loads `fetch_addr` from the newest stack word `stk_words[9:0]`. When two entries are held, the older word `stk_words[19:10]` moves into the newest slot.
- R10: A push always writes the newest slot and moves the previous newest word into the older slot. A third push without a pop discards the oldest entry and raises no error.
- R11: A return with one or zero entries held leaves both stack words unchanged. A return on an empty stack therefore repeats the address delivered by the previous return.
- R12: Operation codes 0, 1, 2, 3 and 5 leave both stack words unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| op_sel | input | 3 | Operation code (0 step, 1 skip, 2 ALU write, 3 short jump, 4 short call, 5 long jump, 6 long call, 7 return) |
| imm_addr | input | 10 | Address field from the instruction word |
| alu_res | input | 8 | ALU result for writes to the low byte |
| page_sel | input | 1 | Page-select status bit |
| fetch_addr | output | 10 | Current program address |
| stk_words | output | 20 | Stack contents: [9:0] newest, [19:10] older |

## Verification
A wrong field rule shows up at `fetch_addr` one clock after the offending operation. A page bit or middle bit taken from the wrong source lands the address in the wrong quarter of program space. A wrong push value or push order shows up at `stk_words` on the same edge as the call. An error in the entry count stays hidden until the stack runs low, and only shows up as a wrong return address on the second or third return after it. For that reason the return sequences are run all the way past an empty stack, and across an overflow.

// File: rtl/pcu_pkg.sv
package pcu_pkg;

    localparam int LOW_W    = 8;
    localparam int ADDR_W   = LOW_W + 2;
    localparam int STK_LVLS = 2;

    typedef enum logic [2:0] {
        OP_STEP  = 3'd0,
        OP_SKIP  = 3'd1,
        OP_WRPC  = 3'd2,
        OP_SJMP  = 3'd3,
        OP_SCALL = 3'd4,
        OP_LJMP  = 3'd5,
        OP_LCALL = 3'd6,
        OP_RET   = 3'd7
    } pc_op_e;

    typedef struct packed {
        logic push;
        logic pop;
    } stk_ctl_t;

    function automatic stk_ctl_t op_stack_ctl(input pc_op_e op);
        stk_ctl_t c;
        c.push = (op == OP_SCALL) || (op == OP_LCALL);
        c.pop  = (op == OP_RET);
        return c;
    endfunction

endpackage

// File: rtl/pcu_next_sel.sv
module pcu_next_sel
    import pcu_pkg::*;
#(
    parameter int LOW_W = pcu_pkg::LOW_W
) (
    input  pc_op_e              op,
    input  logic [LOW_W+1:0]    cur_pc,
    input  logic [LOW_W+1:0]    imm,
    input  logic [LOW_W-1:0]    alu,
    input  logic                page,
    input  logic [LOW_W+1:0]    stk_head,
    output logic [LOW_W+1:0]    nxt_pc,
    output logic [LOW_W+1:0]    ret_addr
);
    localparam int ADDR_W = LOW_W + 2;
    localparam logic [ADDR_W-1:0] INC_ONE = ADDR_W'(1);
    localparam logic [ADDR_W-1:0] INC_TWO = ADDR_W'(2);

    logic [ADDR_W-1:0] plus_one;
    logic [ADDR_W-1:0] plus_two;

    assign plus_one = cur_pc + INC_ONE;
    assign plus_two = cur_pc + INC_TWO;
    assign ret_addr = plus_one;

    always_comb begin
        case (op)
            OP_STEP:  nxt_pc = plus_one;
            OP_SKIP:  nxt_pc = plus_two;
            OP_WRPC:  nxt_pc = {page, 1'b0, alu};
            OP_SJMP:  nxt_pc = {page, imm[LOW_W], imm[LOW_W-1:0]};
            OP_SCALL: nxt_pc = {page, 1'b0, imm[LOW_W-1:0]};
            OP_LJMP:  nxt_pc = imm;
            OP_LCALL: nxt_pc = imm;
            OP_RET:   nxt_pc = stk_head;
            default:  nxt_pc = plus_one;
        endcase
    end

endmodule

// File: rtl/pcu_ret_stack.sv
module pcu_ret_stack #(
    parameter int W    = pcu_pkg::ADDR_W,
    parameter int LVLS = pcu_pkg::STK_LVLS
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            push,
    input  logic            pop,
    input  logic [W-1:0]    push_val,
    output logic [W-1:0]    head,
    output logic [W*LVLS-1:0] words
);
    localparam int CNT_W = $clog2(LVLS + 1);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(LVLS);
    localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);

    logic [W-1:0]     ent [LVLS];
    logic [CNT_W-1:0] held;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < LVLS; i++) ent[i] <= '0;
            held <= '0;
        end else if (push) begin
            ent[0] <= push_val;
            for (int i = 1; i < LVLS; i++) ent[i] <= ent[i-1];
            if (held != CNT_FULL) held <= held + CNT_ONE;
        end else if (pop) begin
            if (held > CNT_ONE) begin
                for (int i = 0; i < LVLS - 1; i++) ent[i] <= ent[i+1];
            end
            if (held != '0) held <= held - CNT_ONE;
        end
    end

    assign head = ent[0];

    for (genvar g = 0; g < LVLS; g++) begin : g_flat
        assign words[g*W +: W] = ent[g];
    end

endmodule

// File: rtl/pcu_top.sv
module pcu_top
    import pcu_pkg::*;
#(
    parameter int LOW_W    = pcu_pkg::LOW_W,
    parameter int STK_LVLS = pcu_pkg::STK_LVLS
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic [2:0]                  op_sel,
    input  logic [LOW_W+1:0]            imm_addr,
    input  logic [LOW_W-1:0]            alu_res,
    input  logic                        page_sel,
    output logic [LOW_W+1:0]            fetch_addr,
    output logic [(LOW_W+2)*STK_LVLS-1:0] stk_words
);
    localparam int ADDR_W = LOW_W + 2;

    pc_op_e            op;
    stk_ctl_t          sctl;
    logic [ADDR_W-1:0] pc_q;
    logic [ADDR_W-1:0] pc_d;
    logic [ADDR_W-1:0] link_addr;
    logic [ADDR_W-1:0] stk_head;

    assign op   = pc_op_e'(op_sel);
    assign sctl = op_stack_ctl(op);

    pcu_next_sel #(.LOW_W(LOW_W)) u_next (
        .op       (op),
        .cur_pc   (pc_q),
        .imm      (imm_addr),
        .alu      (alu_res),
        .page     (page_sel),
        .stk_head (stk_head),
        .nxt_pc   (pc_d),
        .ret_addr (link_addr)
    );

    pcu_ret_stack #(.W(ADDR_W), .LVLS(STK_LVLS)) u_stack (
        .clk      (clk),
        .rst      (rst),
        .push     (sctl.push),
        .pop      (sctl.pop),
        .push_val (link_addr),
        .head     (stk_head),
        .words    (stk_words)
    );

    always_ff @(posedge clk) begin
        if (rst) pc_q <= '0;
        else     pc_q <= pc_d;
    end

    assign fetch_addr = pc_q;

endmodule

// File: rtl/pcu_chk.sv
module pcu_chk
    import pcu_pkg::*;
#(
    parameter int ADDR_W = pcu_pkg::ADDR_W,
    parameter int LVLS   = pcu_pkg::STK_LVLS
) (
    input logic                   clk,
    input logic                   rst,
    input logic [2:0]             op_sel,
    input logic [ADDR_W-1:0]      imm_addr,
    input logic [ADDR_W-3:0]      alu_res,
    input logic                   page_sel,
    input logic [ADDR_W-1:0]      fetch_addr,
    input logic [ADDR_W*LVLS-1:0] stk_words
);
    localparam logic [ADDR_W-1:0] ONE = ADDR_W'(1);
    localparam logic [ADDR_W-1:0] TWO = ADDR_W'(2);

    // R1
    reset_state_chk: assert property (@(posedge clk)
        rst |=> (fetch_addr == '0) && (stk_words == '0));

    // R2
    step_inc_chk: assert property (@(posedge clk) disable iff (rst)
        (op_sel == OP_STEP) |=> fetch_addr == $past(fetch_addr) + ONE);

    // R3
    skip_inc_chk: assert property (@(posedge clk) disable iff (rst)
        (op_sel == OP_SKIP) |=> fetch_addr == $past(fetch_addr) + TWO);

    // R4
    alu_write_chk: assert property (@(posedge clk) disable iff (rst)
        (op_sel == OP_WRPC) |=> fetch_addr == {$past(page_sel), 1'b0, $past(alu_res)});

    // R7
    long_jump_chk: assert property (@(posedge clk) disable iff (rst)
        (op_sel == OP_LJMP) |=> fetch_addr == $past(imm_addr));

    // R6
    call_push_chk: assert property (@(posedge clk) disable iff (rst)
        (op_sel == OP_SCALL || op_sel == OP_LCALL)
        |=> stk_words[ADDR_W-1:0] == $past(fetch_addr) + ONE);

    // R9
    return_pop_chk: assert property (@(posedge clk) disable iff (rst)
        (op_sel == OP_RET) |=> fetch_addr == $past(stk_words[ADDR_W-1:0]));

    // R12
    stack_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (op_sel != OP_SCALL && op_sel != OP_LCALL && op_sel != OP_RET)
        |=> $stable(stk_words));

endmodule

bind pcu_top pcu_chk #(.ADDR_W(ADDR_W), .LVLS(STK_LVLS)) u_pcu_chk (
    .clk        (clk),
    .rst        (rst),
    .op_sel     (op_sel),
    .imm_addr   (imm_addr),
    .alu_res    (alu_res),
    .page_sel   (page_sel),
    .fetch_addr (fetch_addr),
    .stk_words  (stk_words)
);

// File: tb/test_pcu_top.sv
`timescale 1ns/1ps
module test_pcu_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [2:0]  op_sel = 3'd0;
    logic [9:0]  imm_addr = '0;
    logic [7:0]  alu_res = '0;
    logic        page_sel = 1'b0;
    logic [9:0]  fetch_addr;
    logic [19:0] stk_words;

    int n_chk  = 0;
    int n_fail = 0;

    localparam logic [2:0] STEP = 3'd0, SKIP = 3'd1, WRPC = 3'd2, SJMP = 3'd3,
                           SCALL = 3'd4, LJMP = 3'd5, LCALL = 3'd6, RET = 3'd7;

    always #2 clk = ~clk;

    pcu_top i_pcu_top (
        .clk        (clk),
        .rst        (rst),
        .op_sel     (op_sel),
        .imm_addr   (imm_addr),
        .alu_res    (alu_res),
        .page_sel   (page_sel),
        .fetch_addr (fetch_addr),
        .stk_words  (stk_words)
    );

    task automatic chk(input string tag, input logic [19:0] got, input logic [19:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    // Drive one operation 1 ns after an edge, wait for the next edge, sample 1 ns later.
    task automatic apply(input logic [2:0] op, input logic [9:0] imm,
                         input logic [7:0] alu, input logic pg);
        op_sel   = op;
        imm_addr = imm;
        alu_res  = alu;
        page_sel = pg;
        @(posedge clk);
        #1;
    endtask

    task automatic do_reset();
        op_sel   = LCALL;
        imm_addr = 10'h3FF;
        page_sel = 1'b1;
        rst      = 1'b1;
        repeat (2) @(posedge clk);
        #1;
        rst = 1'b0;
        // R1: reset wins over a pending long call
        chk("R1 fetch after reset", {10'h0, fetch_addr}, 20'h0);
        chk("R1 stack after reset", stk_words, 20'h0);
    endtask

    task automatic t_step();
        apply(STEP, 10'h3AA, 8'h11, 1'b1);
        apply(STEP, 10'h0, 8'h0, 1'b0);
        apply(STEP, 10'h0, 8'h0, 1'b0);
        chk("R2 three steps", {10'h0, fetch_addr}, 20'h3);
        chk("R12 step keeps stack", stk_words, 20'h0);
        apply(LJMP, 10'h3FF, 8'h0, 1'b0);
        chk("R7 long jump to 3FF", {10'h0, fetch_addr}, 20'h3FF);
        apply(STEP, 10'h0, 8'h0, 1'b0);
        chk("R2 wrap 3FF to 000", {10'h0, fetch_addr}, 20'h0);
    endtask

    task automatic t_skip();
        apply(LJMP, 10'h3FE, 8'h0, 1'b0);
        apply(SKIP, 10'h0, 8'h0, 1'b0);
        chk("R3 skip 3FE wraps to 000", {10'h0, fetch_addr}, 20'h0);
        apply(SKIP, 10'h0, 8'h0, 1'b1);
        chk("R3 skip 000 to 002", {10'h0, fetch_addr}, 20'h2);
        apply(LJMP, 10'h3FF, 8'h0, 1'b0);
        apply(SKIP, 10'h0, 8'h0, 1'b0);
        chk("R3 skip 3FF to 001", {10'h0, fetch_addr}, 20'h1);
        chk("R12 skip keeps stack", stk_words, 20'h0);
    endtask

    task automatic t_wrpc();
        apply(LJMP, 10'h1F0, 8'h0, 1'b0);
        apply(WRPC, 10'h3FF, 8'hA5, 1'b1);
        chk("R4 ALU write page 1", {10'h0, fetch_addr}, 20'h2A5);
        apply(WRPC, 10'h3FF, 8'h3C, 1'b0);
        chk("R4 ALU write page 0, bit 8 cleared", {10'h0, fetch_addr}, 20'h03C);
        chk("R12 ALU write keeps stack", stk_words, 20'h0);
    endtask

    task automatic t_sjmp();
        apply(SJMP, 10'h35A, 8'hFF, 1'b1);
        chk("R5 short jump page 1", {10'h0, fetch_addr}, 20'h35A);
        apply(SJMP, 10'h2C3, 8'h00, 1'b0);
        chk("R5 short jump ignores imm bit 9", {10'h0, fetch_addr}, 20'h0C3);
        apply(SJMP, 10'h1FF, 8'h00, 1'b0);
        chk("R5 short jump keeps imm bit 8", {10'h0, fetch_addr}, 20'h1FF);
    endtask

    task automatic t_ljmp();
        apply(LJMP, 10'h2F0, 8'h00, 1'b0);
        chk("R7 long jump ignores page 0", {10'h0, fetch_addr}, 20'h2F0);
        apply(LJMP, 10'h010, 8'h00, 1'b1);
        chk("R7 long jump ignores page 1", {10'h0, fetch_addr}, 20'h010);
        chk("R12 jumps keep stack", stk_words, 20'h0);
    endtask

    task automatic t_call_ret();
        do_reset();
        apply(LJMP, 10'h120, 8'h0, 1'b0);
        apply(SCALL, 10'h3FF, 8'h0, 1'b1);
        chk("R6 short call target", {10'h0, fetch_addr}, 20'h2FF);
        chk("R6 short call push", stk_words, {10'h000, 10'h121});
        apply(LCALL, 10'h3FF, 8'h0, 1'b0);
        chk("R8 long call target", {10'h0, fetch_addr}, 20'h3FF);
        chk("R10 second push shifts", stk_words, {10'h121, 10'h300});
        apply(RET, 10'h0AA, 8'h0, 1'b1);
        chk("R9 return newest", {10'h0, fetch_addr}, 20'h300);
        chk("R9 older moves up", stk_words, {10'h121, 10'h121});
        apply(RET, 10'h0, 8'h0, 1'b0);
        chk("R9 second return", {10'h0, fetch_addr}, 20'h121);
        apply(RET, 10'h0, 8'h0, 1'b0);
        chk("R11 empty return repeats", {10'h0, fetch_addr}, 20'h121);
        chk("R11 empty return keeps stack", stk_words, {10'h121, 10'h121});
    endtask

    task automatic t_overflow();
        do_reset();
        apply(LJMP, 10'h010, 8'h0, 1'b0);
        apply(LCALL, 10'h100, 8'h0, 1'b0);
        apply(LCALL, 10'h200, 8'h0, 1'b0);
        apply(LCALL, 10'h3FF, 8'h0, 1'b0);
        chk("R10 third push drops oldest", stk_words, {10'h101, 10'h201});
        apply(STEP, 10'h0, 8'h0, 1'b0);
        chk("R12 step keeps full stack", stk_words, {10'h101, 10'h201});
        apply(LJMP, 10'h3FF, 8'h0, 1'b0);
        apply(LCALL, 10'h050, 8'h0, 1'b0);
        chk("R8 call from 3FF pushes 000", stk_words, {10'h201, 10'h000});
        apply(RET, 10'h0, 8'h0, 1'b0);
        chk("R9 return to wrapped 000", {10'h0, fetch_addr}, 20'h000);
        apply(RET, 10'h0, 8'h0, 1'b0);
        chk("R9 return to 201", {10'h0, fetch_addr}, 20'h201);
        apply(RET, 10'h0, 8'h0, 1'b0);
        chk("R11 underflow repeats 201", {10'h0, fetch_addr}, 20'h201);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        rst = 1'b0;
        chk("R1 fetch at start", {10'h0, fetch_addr}, 20'h0);
        do_reset();
        t_step();
        t_skip();
        t_wrpc();
        t_sjmp();
        t_ljmp();
        t_call_ret();
        t_overflow();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #(4 * 200000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule